// File: doc/BRIEF.md
# ADC result DMA address generator

This block sits between the sequencer of a multichannel analog-to-digital converter and a DMA channel. For every accepted conversion result it computes the word address where the result belongs in the DMA buffer. It then stages the result until its conversion sequence ends, and hands the words to the DMA channel as single-cycle requests, each carrying its address and data.

Two placement schemes are available. Ordered placement writes results one after another in conversion order, using a running word offset. Scatter/gather placement gives each analog input its own region of the buffer, sized by a power-of-two setting, and a shared pointer picks the slot inside each region. The pointer advances once every programmable number of sequences and wraps at the region size. Settings are captured only while the block is disabled, and enabling it starts from a clean pointer.

Top module: `adc_result_addr_gen`

## Requirements
- R1: While reset is asserted, and until a sequence has ended, `dma_req` is 0 and `dma_addr` and `dma_data` read 0. Both buses read 0 in every cycle where `dma_req` is 0.
- R2: With `cfg_ordered`=0 (scatter/gather), a result from input `conv_ch` is placed at `conv_ch * 2^cfg_size + P`, where P is the current slot pointer. The `cfg_size` code k (0..7) selects a region of 2^k words.
- R3: With `cfg_ordered`=1 (ordered), the address is a running offset. It starts at 0, grows by 1 for each accepted result, and returns to 0 when an advance period ends.
- R4: An advance period is `cfg_spi`+1 sequence ends. When one completes, P becomes (P+1) mod 2^cfg_size. A result that arrives in the same cycle as the period-ending `seq_done` still uses the old P and the old offset.
- R5: The results of a sequence are released by its `seq_done`, counting a result in the same cycle. The first word's request appears in the cycle after that edge. Words follow one per cycle in conversion order, and no request occurs without a prior release.
- R6: At most 4 results are accepted per sequence. Further `conv_valid` strobes before `seq_done` are discarded and advance neither the offset nor the output.
- R7: `cfg_ordered`, `cfg_spi` and `cfg_size` are sampled only on clock edges where `enable` is 0. Changes while enabled have no effect on addresses.
- R8: With `enable` at 0, staged words are discarded and no request is raised after the next edge. P, the offset and the sequence count return to 0, so the first result after enabling uses P=0.
- R9: `dma_data` carries the `conv_data` value of the same result whose address is on `dma_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; 0 flushes state and opens the settings |
| cfg_ordered | input | 1 | 1 = ordered placement, 0 = scatter/gather |
| cfg_spi | input | 4 | Sequences per pointer advance, minus one |
| cfg_size | input | 3 | Region size code k, 2^k words |
| conv_valid | input | 1 | One conversion result is present this cycle |
| conv_ch | input | 5 | Analog input index of the result |
| conv_data | input | 12 | Conversion result value |
| seq_done | input | 1 | The current conversion sequence ends this cycle |
| dma_req | output | 1 | One-cycle transfer request per result word |
| dma_addr | output | 12 | Word address for the request |
| dma_data | output | 12 | Result word for the request |

## Verification
The main function is swept over both placement modes, every region size code and several advance periods. Inside each sweep the sequence lengths run from empty to beyond the per-sequence cap, and the gaps between sequences range from none to several idle cycles. The input indices follow a spread-out arithmetic pattern, so that a wrong region multiplier or a stale pointer shows up as a distinct address. Back-to-back sequences separate correct release ordering from a design that drains only when idle. Empty sequences check that sequence ends, not results, drive the advance count. Settings are changed while enabled to show that only the captured copy matters. Dedicated runs cover a disable during draining, the pointer clear on re-enable, and the overflow of the result cap.

// File: rtl/adcdma_pkg.sv
package adcdma_pkg;

  typedef enum logic {
    PLACE_SCATTER = 1'b0,
    PLACE_ORDERED = 1'b1
  } place_e;

  // Mask of valid slot indices for a region of 2^code words.
  function automatic logic [31:0] slot_mask(input logic [31:0] code);
    return (32'd1 << code) - 32'd1;
  endfunction

  // First word of the region that belongs to one analog input.
  function automatic logic [31:0] region_base(input logic [31:0] ch,
                                              input logic [31:0] code);
    return ch << code;
  endfunction

  // Scatter/gather word address: region base plus slot.
  function automatic logic [31:0] scatter_addr(input logic [31:0] ch,
                                               input logic [31:0] slot,
                                               input logic [31:0] code);
    return region_base(ch, code) + slot;
  endfunction

  // Slot pointer after one advance, wrapping at the region size.
  function automatic logic [31:0] slot_next(input logic [31:0] slot,
                                            input logic [31:0] code);
    return (slot + 32'd1) & slot_mask(code);
  endfunction

endpackage

// File: rtl/adcdma_cfg_shadow.sv
module adcdma_cfg_shadow #(
  parameter int SPI_W = 4,
  parameter int SZ_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_ordered,
  input  logic [SPI_W-1:0] cfg_spi,
  input  logic [SZ_W-1:0]  cfg_size,
  output logic             sh_ordered,
  output logic [SPI_W-1:0] sh_spi,
  output logic [SZ_W-1:0]  sh_size
);

  // Settings are open only while the block is disabled.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_ordered <= 1'b0;
      sh_spi     <= '0;
      sh_size    <= '0;
    end else if (!enable) begin
      sh_ordered <= cfg_ordered;
      sh_spi     <= cfg_spi;
      sh_size    <= cfg_size;
    end
  end

endmodule

// File: rtl/adcdma_seq_track.sv
module adcdma_seq_track
  import adcdma_pkg::*;
#(
  parameter int SPI_W  = 4,
  parameter int SZ_W   = 3,
  parameter int PTR_W  = 7,
  parameter int OFS_W  = 12,
  parameter int NSH    = 4,
  parameter int FILL_W = $clog2(NSH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              conv_valid,
  input  logic              seq_done,
  input  logic [SPI_W-1:0]  sh_spi,
  input  logic [SZ_W-1:0]   sh_size,
  output logic              accept,
  output logic              period_end,
  output logic [PTR_W-1:0]  ptr,
  output logic [OFS_W-1:0]  ofs,
  output logic [FILL_W-1:0] fill
);

  logic [SPI_W-1:0] seq_cnt_q;
  logic [31:0]      ptr_adv;

  // A result is taken while the sequence still has a free sample slot.
  assign accept     = enable && conv_valid && (fill < FILL_W'(NSH));
  // The last sequence end of an advance period.
  assign period_end = enable && seq_done && (seq_cnt_q == sh_spi);
  assign ptr_adv    = slot_next(32'(ptr), 32'(sh_size));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      ptr <= '0;
    end else if (period_end) begin
      ptr <= ptr_adv[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      ofs <= '0;
    end else if (period_end) begin
      ofs <= '0;
    end else if (accept) begin
      ofs <= ofs + OFS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      seq_cnt_q <= '0;
    end else if (seq_done) begin
      seq_cnt_q <= period_end ? '0 : seq_cnt_q + SPI_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      fill <= '0;
    end else if (seq_done) begin
      fill <= '0;
    end else if (accept) begin
      fill <= fill + FILL_W'(1);
    end
  end

endmodule

// File: rtl/adcdma_addr_sel.sv
module adcdma_addr_sel
  import adcdma_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int SZ_W   = 3,
  parameter int PTR_W  = 7,
  parameter int ADDR_W = 12
) (
  input  logic              sh_ordered,
  input  logic [SZ_W-1:0]   sh_size,
  input  logic [CH_W-1:0]   ch,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [ADDR_W-1:0] ofs,
  output logic [ADDR_W-1:0] addr
);

  logic [31:0] sg_full;
  place_e      mode;

  assign mode    = place_e'(sh_ordered);
  assign sg_full = scatter_addr(32'(ch), 32'(ptr), 32'(sh_size));

  always_comb begin
    if (mode == PLACE_ORDERED) begin
      addr = ofs;
    end else begin
      addr = sg_full[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/adcdma_stage_fifo.sv
module adcdma_stage_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 24,
  parameter int IW    = $clog2(DEPTH),
  parameter int PW    = IW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_word,
  input  logic         release_now,
  output logic         avail,
  output logic         full,
  output logic [W-1:0] head
);

  // DEPTH must be a power of two so that the pointers wrap naturally.
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_q, rd_q, rel_q;
  logic [PW-1:0] occ;
  logic          do_push;

  assign occ     = wr_q - rd_q;
  assign full    = (occ == PW'(DEPTH));
  assign do_push = push && !full;
  // Words up to the release mark may leave; one leaves per cycle.
  assign avail   = (rd_q != rel_q);
  assign head    = store[rd_q[IW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) begin
      store[wr_q[IW-1:0]] <= push_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      rel_q <= '0;
    end else begin
      if (do_push) begin
        wr_q <= wr_q + PW'(1);
      end
      if (avail) begin
        rd_q <= rd_q + PW'(1);
      end
      if (release_now) begin
        rel_q <= do_push ? wr_q + PW'(1) : wr_q;
      end
    end
  end

endmodule

// File: rtl/adc_result_addr_gen.sv
module adc_result_addr_gen #(
  parameter int CH_W   = 5,
  parameter int DATA_W = 12,
  parameter int SPI_W  = 4,
  parameter int SZ_W   = 3,
  parameter int NSH    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_ordered,
  input  logic [SPI_W-1:0]  cfg_spi,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic              conv_valid,
  input  logic [CH_W-1:0]   conv_ch,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              seq_done,
  output logic              dma_req,
  output logic [CH_W+(2**SZ_W)-1-1:0] dma_addr,
  output logic [DATA_W-1:0] dma_data
);

  localparam int PTR_W  = (2 ** SZ_W) - 1;
  localparam int ADDR_W = CH_W + PTR_W;
  localparam int DEPTH  = 2 * NSH;
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int FILL_W = $clog2(NSH + 1);

  // Named internal events, also observed by the bound checker.
  logic              sh_ordered;
  logic [SPI_W-1:0]  sh_spi;
  logic [SZ_W-1:0]   sh_size;
  logic              accept;
  logic              period_end;
  logic [PTR_W-1:0]  ptr;
  logic [ADDR_W-1:0] ofs;
  logic [FILL_W-1:0] fill;
  logic [ADDR_W-1:0] place_addr;
  logic              stg_full;
  logic              stg_avail;
  logic [WORD_W-1:0] stg_head;

  adcdma_cfg_shadow #(
    .SPI_W(SPI_W),
    .SZ_W (SZ_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_ordered(cfg_ordered),
    .cfg_spi    (cfg_spi),
    .cfg_size   (cfg_size),
    .sh_ordered (sh_ordered),
    .sh_spi     (sh_spi),
    .sh_size    (sh_size)
  );

  adcdma_seq_track #(
    .SPI_W (SPI_W),
    .SZ_W  (SZ_W),
    .PTR_W (PTR_W),
    .OFS_W (ADDR_W),
    .NSH   (NSH),
    .FILL_W(FILL_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .conv_valid(conv_valid),
    .seq_done  (seq_done),
    .sh_spi    (sh_spi),
    .sh_size   (sh_size),
    .accept    (accept),
    .period_end(period_end),
    .ptr       (ptr),
    .ofs       (ofs),
    .fill      (fill)
  );

  adcdma_addr_sel #(
    .CH_W  (CH_W),
    .SZ_W  (SZ_W),
    .PTR_W (PTR_W),
    .ADDR_W(ADDR_W)
  ) u_sel (
    .sh_ordered(sh_ordered),
    .sh_size   (sh_size),
    .ch        (conv_ch),
    .ptr       (ptr),
    .ofs       (ofs),
    .addr      (place_addr)
  );

  adcdma_stage_fifo #(
    .DEPTH(DEPTH),
    .W    (WORD_W)
  ) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (!enable),
    .push       (accept),
    .push_word  ({place_addr, conv_data}),
    .release_now(enable && seq_done),
    .avail      (stg_avail),
    .full       (stg_full),
    .head       (stg_head)
  );

  assign dma_req  = stg_avail;
  assign dma_addr = stg_avail ? stg_head[WORD_W-1:DATA_W] : '0;
  assign dma_data = stg_avail ? stg_head[DATA_W-1:0] : '0;

endmodule

// File: rtl/adcdma_chk.sv
module adcdma_chk #(
  parameter int SPI_W  = 4,
  parameter int SZ_W   = 3,
  parameter int PTR_W  = 7,
  parameter int ADDR_W = 12,
  parameter int NSH    = 4,
  parameter int FILL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              seq_done,
  input logic              dma_req,
  input logic              accept,
  input logic              stg_full,
  input logic [FILL_W-1:0] fill,
  input logic [PTR_W-1:0]  ptr,
  input logic [ADDR_W-1:0] ofs,
  input logic              period_end,
  input logic              sh_ordered,
  input logic [SPI_W-1:0]  sh_spi,
  input logic [SZ_W-1:0]   sh_size
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !stg_full); // R6

  AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (fill <= FILL_W'(NSH))); // R6

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr >> sh_size) == '0); // R4

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !period_end) |=> $stable(ptr)); // R4

  AST_OFS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (ofs == '0)); // R3

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable({sh_ordered, sh_spi, sh_size})); // R7

  AST_NO_REQ_UNRELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && !seq_done) |=> !dma_req); // R5

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !dma_req); // R8

endmodule

bind adc_result_addr_gen adcdma_chk #(
  .SPI_W (SPI_W),
  .SZ_W  (SZ_W),
  .PTR_W (PTR_W),
  .ADDR_W(ADDR_W),
  .NSH   (NSH),
  .FILL_W(FILL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .seq_done  (seq_done),
  .dma_req   (dma_req),
  .accept    (accept),
  .stg_full  (stg_full),
  .fill      (fill),
  .ptr       (ptr),
  .ofs       (ofs),
  .period_end(period_end),
  .sh_ordered(sh_ordered),
  .sh_spi    (sh_spi),
  .sh_size   (sh_size)
);

// File: tb/adc_result_addr_gen_tb.sv
`timescale 1ns/1ps
module adc_result_addr_gen_tb;

  localparam int CH_W   = 5;
  localparam int DATA_W = 12;
  localparam int SPI_W  = 4;
  localparam int SZ_W   = 3;
  localparam int NSH    = 4;
  localparam int ADDR_W = CH_W + (2 ** SZ_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              enable;
  logic              cfg_ordered;
  logic [SPI_W-1:0]  cfg_spi;
  logic [SZ_W-1:0]   cfg_size;
  logic              conv_valid;
  logic [CH_W-1:0]   conv_ch;
  logic [DATA_W-1:0] conv_data;
  logic              seq_done;
  logic              dma_req;
  logic [ADDR_W-1:0] dma_addr;
  logic [DATA_W-1:0] dma_data;

  always #2 clk = ~clk;

  adc_result_addr_gen #(
    .CH_W(CH_W), .DATA_W(DATA_W), .SPI_W(SPI_W), .SZ_W(SZ_W), .NSH(NSH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_ordered(cfg_ordered),
    .cfg_spi(cfg_spi), .cfg_size(cfg_size), .conv_valid(conv_valid),
    .conv_ch(conv_ch), .conv_data(conv_data), .seq_done(seq_done),
    .dma_req(dma_req), .dma_addr(dma_addr), .dma_data(dma_data)
  );

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  int    cyc = 0;
  int    words_seen = 0;
  int    last_addr = 0;
  string ph_tag = "R2";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference model: captured settings, pointer, offset, counts, queues.
  bit m_ord;
  int m_spi, m_sz, m_ptr, m_ofs, m_cnt, m_fill;
  logic [ADDR_W+DATA_W-1:0] pend_q[$];
  logic [ADDR_W+DATA_W-1:0] rel_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ord = 0; m_spi = 0; m_sz = 0;
      m_ptr = 0; m_ofs = 0; m_cnt = 0; m_fill = 0;
      pend_q.delete(); rel_q.delete();
    end else if (!enable) begin
      m_ord = cfg_ordered; m_spi = int'(cfg_spi); m_sz = int'(cfg_size);
      m_ptr = 0; m_ofs = 0; m_cnt = 0; m_fill = 0;
      pend_q.delete(); rel_q.delete();
    end else begin
      if (conv_valid && m_fill < NSH) begin
        int a;
        a = m_ord ? m_ofs : int'(conv_ch) * (1 << m_sz) + m_ptr;
        pend_q.push_back({a[ADDR_W-1:0], conv_data});
        m_fill++;
        m_ofs++;
      end
      if (seq_done) begin
        while (pend_q.size() > 0) rel_q.push_back(pend_q.pop_front());
        m_fill = 0;
        if (m_cnt == m_spi) begin
          m_cnt = 0;
          m_ptr = (m_ptr + 1) % (1 << m_sz);
          m_ofs = 0;
        end else begin
          m_cnt++;
        end
      end
    end
  end

  // Cycle-accurate output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rel_q.size() > 0) begin
        logic [ADDR_W+DATA_W-1:0] e;
        e = rel_q.pop_front();
        chk(dma_req === 1'b1, "R5", "request for released word", dma_req, 1);
        chk(dma_addr === e[ADDR_W+DATA_W-1:DATA_W], ph_tag, "address",
            dma_addr, e[ADDR_W+DATA_W-1:DATA_W]);
        chk(dma_data === e[DATA_W-1:0], "R9", "data", dma_data, e[DATA_W-1:0]);
      end else begin
        chk(dma_req === 1'b0, "R5", "request with nothing released", dma_req, 0);
        chk(dma_addr === '0 && dma_data === '0, "R1", "idle buses", dma_addr, 0);
      end
      if (dma_req === 1'b1) begin
        words_seen++;
        last_addr = int'(dma_addr);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R5 watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic configure(input bit ord, input int spi, input int sz);
    @(negedge clk);
    enable = 0; conv_valid = 0; seq_done = 0;
    cfg_ordered = ord; cfg_spi = spi[SPI_W-1:0]; cfg_size = sz[SZ_W-1:0];
    repeat (2) @(negedge clk);
    enable = 1;
  endtask

  task automatic run_seq(input int n, input int s, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      conv_valid = 1;
      conv_ch    = CH_W'((s * 7 + i * 3 + 1) % 32);
      conv_data  = DATA_W'((s * 37 + i * 11 + 5) % 4096);
      seq_done   = (i == n - 1);
    end
    if (n == 0) begin
      @(negedge clk);
      conv_valid = 0; seq_done = 1;
    end
    @(negedge clk);
    conv_valid = 0; seq_done = 0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    int wb;
    rst_n = 0; enable = 0; cfg_ordered = 0; cfg_spi = '0; cfg_size = '0;
    conv_valid = 0; conv_ch = '0; conv_data = '0; seq_done = 0;
    repeat (3) @(negedge clk);
    chk(dma_req === 1'b0, "R1", "reset request", dma_req, 0);
    chk(dma_addr === '0, "R1", "reset address", dma_addr, 0);
    chk(dma_data === '0, "R1", "reset data", dma_data, 0);
    rst_n = 1;

    // Sweep: both modes, every size code, three advance periods.
    for (int mode = 0; mode < 2; mode++) begin
      for (int sz = 0; sz < 8; sz++) begin
        for (int k = 0; k < 3; k++) begin
          int spi;
          spi = (k == 0) ? 0 : (k == 1) ? 1 : 3;
          ph_tag = mode ? "R3/R7" : "R2/R4/R7";
          configure(mode[0], spi, sz);
          // Settings change while enabled and must be ignored.
          @(negedge clk);
          cfg_ordered = ~mode[0]; cfg_spi = ~spi[SPI_W-1:0];
          cfg_size = SZ_W'(sz ^ 5);
          for (int s = 0; s < (spi + 1) * 5 + 3; s++) begin
            run_seq(s % 6, s + sz, (s % 2 == 1) ? 0 : NSH);
          end
          repeat (NSH + 2) @(negedge clk);
        end
      end
    end

    // R6: six strobes in one sequence, only four words come out.
    ph_tag = "R3/R6";
    configure(1'b1, 0, 0);
    repeat (2) @(negedge clk);
    wb = words_seen;
    run_seq(6, 3, NSH + 4);
    chk(words_seen - wb == NSH, "R6", "words from an over-long sequence",
        words_seen - wb, NSH);

    // R8: disable while draining, then re-enable clears the pointer.
    ph_tag = "R2/R8";
    configure(1'b0, 0, 2);
    for (int s = 0; s < 3; s++) run_seq(1, s, NSH);
    wb = words_seen;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      conv_valid = 1; conv_ch = CH_W'(9 + i); conv_data = DATA_W'(100 + i);
      seq_done = (i == 2);
    end
    @(negedge clk);
    conv_valid = 0; seq_done = 0; enable = 0;
    repeat (4) @(negedge clk);
    chk(words_seen - wb == 1, "R8", "words after disable mid-drain",
        words_seen - wb, 1);
    enable = 1;
    run_seq(1, 0, NSH);
    chk(last_addr == 4, "R8", "first address after re-enable (ch 1, P=0)",
        last_addr, 4);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule